// File: doc/BRIEF.md
# Shadowed BCD Calendar Register Bank

This block keeps time of day and date as a chain of BCD counters (seconds, minutes, hours in 24-hour form, weekday, day of month, month and two-digit year), advanced by a one-cycle 1 Hz strobe. The host never sees the counters directly. It reads a bank of seven holding bytes plus a control byte through a byte-wide port with a 3-bit address. All seven holding bytes are loaded from the counters in one clock cycle, once per second.

A halt bit in the control byte freezes the holding bytes so that software can read a consistent time while the counters keep running. While halted, the host may also write a time byte. That byte lands in the holding register and in the matching counter, which is how the time is set. Clearing the halt bit does not refresh the bank at once. The next second strobe does. The control byte also stores a calibration value that is driven out on its own port for a trimming stage elsewhere.

A small state machine sequences the refresh. It has four states. RUN is the normal refreshing state. COPY is the single cycle in which the bank is loaded. HALT means frozen. ARMED means the halt has been released and the bank waits for the next strobe. The transitions are:

- RUN to COPY on a strobe.
- RUN to HALT when halt is set.
- COPY to RUN after one cycle, or COPY to HALT if halt is set by then.
- HALT to ARMED when halt is cleared.
- ARMED to COPY on a strobe.
- ARMED to HALT when halt is set again.

Top module: `cal_shadow_top`

## Requirements
- R1: After reset the counters and holding bytes read seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01 and year 00. The control byte and the calibration output are 0.
- R2: Register offsets: 0 is control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year. Read data is combinational from the addressed byte.
- R3: Seconds and minutes count in BCD from 00 to 59 and wrap to 00 with a carry. Hours count 00 to 23 and wrap to 00 with a day carry. A low digit of 9 rolls into the tens digit.
- R4: The weekday counts 1 to 7 on each day carry and wraps from 7 to 1.
- R5: The last date is 30 for months 04, 06, 09 and 11, 31 for the other months, and for month 02 it is 28, or 29 when the year read as a decimal number from its BCD digits is divisible by 4. The date then wraps to 01 and advances the month. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R6: When not halted, a strobe sampled at clock edge k advances the counters at k and loads all seven holding bytes together at edge k+1.
- R7: Writing control bit 6 as 1 freezes the holding bytes. The counters keep advancing on every strobe during the halt.
- R8: Setting the halt bit in the same clock cycle in which a bank load is in progress does not cancel that load.
- R9: After bit 6 is written back to 0, the holding bytes stay unchanged until the next strobe, and they then show the current count.
- R10: Control bits 5:0 store the calibration value. That value is driven on `trim_value` and read back. Control bit 7 always reads 0.
- R11: A write to offsets 1 to 7 while the halt bit is 1 loads both the holding byte and its counter at that clock edge. While the halt bit is 0, such a write has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| trim_value | output | 6 | Stored calibration value |

## Verification
The hardest situation to reach is a halt request that lands in the one cycle when the bank is being loaded. A broad write pattern cannot hit that cycle. The bench asserts the strobe for one cycle and drives the control write in the very next cycle, which is the COPY cycle. It then checks that the seconds byte shows the new count. A further strobe follows, and the bench checks that the bank stays frozen. The counts made during a halt are observed after release, by presetting a known time while halted and counting the strobes.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int ADDR_W     = $clog2(NUM_FIELDS + 1);

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    typedef logic [7:0] bcd_t;
    typedef logic [NUM_FIELDS-1:0][7:0] field_vec_t;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_COPY  = 2'd1,
        ST_HALT  = 2'd2,
        ST_ARMED = 2'd3
    } snap_state_e;

    function automatic bcd_t bcd_inc(input bcd_t v);
        bcd_t r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [7:0] bcd_to_bin(input bcd_t v);
        logic [7:0] hi;
        hi = {4'd0, v[7:4]};
        return (hi << 3) + (hi << 1) + {4'd0, v[3:0]};
    endfunction

    function automatic bcd_t last_date(input bcd_t month, input bcd_t year);
        logic [7:0] yb;
        bcd_t r;
        yb = bcd_to_bin(year);
        case (month)
            8'h02:                      r = (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    function automatic bcd_t field_reset(input int idx);
        bcd_t r;
        if (idx == F_DOW || idx == F_DATE || idx == F_MON) r = 8'h01;
        else                                              r = 8'h00;
        return r;
    endfunction

endpackage

// File: rtl/cal_counter_chain.sv
module cal_counter_chain
    import cal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [NUM_FIELDS-1:0] load_en,
    input  logic [7:0]            load_val,
    output field_vec_t            cnt
);

    field_vec_t cnt_q;
    field_vec_t nxt;
    logic       c_sec, c_min, c_hour, c_date, c_mon;
    bcd_t       mday_last;

    always_comb begin
        mday_last = last_date(cnt_q[F_MON], cnt_q[F_YEAR]);
        c_sec     = (cnt_q[F_SEC] == 8'h59);
        c_min     = c_sec && (cnt_q[F_MIN] == 8'h59);
        c_hour    = c_min && (cnt_q[F_HOUR] == 8'h23);
        c_date    = c_hour && (cnt_q[F_DATE] == mday_last);
        c_mon     = c_date && (cnt_q[F_MON] == 8'h12);

        nxt = cnt_q;
        nxt[F_SEC] = c_sec ? 8'h00 : bcd_inc(cnt_q[F_SEC]);
        if (c_sec)
            nxt[F_MIN] = (cnt_q[F_MIN] == 8'h59) ? 8'h00 : bcd_inc(cnt_q[F_MIN]);
        if (c_min)
            nxt[F_HOUR] = (cnt_q[F_HOUR] == 8'h23) ? 8'h00 : bcd_inc(cnt_q[F_HOUR]);
        if (c_hour) begin
            nxt[F_DOW]  = (cnt_q[F_DOW] == 8'h07) ? 8'h01 : bcd_inc(cnt_q[F_DOW]);
            nxt[F_DATE] = (cnt_q[F_DATE] == mday_last) ? 8'h01 : bcd_inc(cnt_q[F_DATE]);
        end
        if (c_date)
            nxt[F_MON] = (cnt_q[F_MON] == 8'h12) ? 8'h01 : bcd_inc(cnt_q[F_MON]);
        if (c_mon)
            nxt[F_YEAR] = (cnt_q[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cnt_q[F_YEAR]);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (!rst_n)          cnt_q[i] <= field_reset(i);
            else if (load_en[i]) cnt_q[i] <= load_val;
            else if (tick)       cnt_q[i] <= nxt[i];
        end
    end

    assign cnt = cnt_q;

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && load_en == '0 && cnt_q[F_SEC] == 8'h59) |=> (cnt_q[F_SEC] == 8'h00)); // R3
    AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && load_en == '0 && c_min && cnt_q[F_HOUR] == 8'h23) |=> (cnt_q[F_HOUR] == 8'h00)); // R3
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && load_en == '0 && c_hour && cnt_q[F_DOW] == 8'h07) |=> (cnt_q[F_DOW] == 8'h01)); // R4
    AST_MONTH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && load_en == '0 && c_date && cnt_q[F_MON] == 8'h12) |=> (cnt_q[F_MON] == 8'h01)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && load_en == '0) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/cal_snapshot_fsm.sv
module cal_snapshot_fsm
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic halt,
    output logic copy_en
);

    snap_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (halt)      state_d = ST_HALT;
                else if (tick) state_d = ST_COPY;
            end
            ST_COPY: begin
                state_d = halt ? ST_HALT : ST_RUN;
            end
            ST_HALT: begin
                if (!halt)     state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (halt)      state_d = ST_HALT;
                else if (tick) state_d = ST_COPY;
            end
            default:           state_d = ST_RUN;
        endcase
    end

    always_comb begin
        copy_en = (state_q == ST_COPY);
    end

    AST_TICK_STARTS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN || state_q == ST_ARMED) && tick && !halt) |=> copy_en); // R6
    AST_COPY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en |=> !copy_en); // R6
    AST_HALT_BLOCKS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !copy_en); // R7
    AST_RELEASE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> !copy_en); // R9

endmodule

// File: rtl/cal_host_regs.sv
module cal_host_regs
    import cal_pkg::*;
#(
    parameter int CAL_W    = 6,
    parameter int HALT_BIT = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            wdata,
    input  logic                  copy_en,
    input  field_vec_t            cnt,
    output logic [7:0]            rdata,
    output logic                  halt,
    output logic [CAL_W-1:0]      cal,
    output logic [NUM_FIELDS-1:0] load_en,
    output logic [7:0]            load_val
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    field_vec_t       hold_q;
    logic             halt_q;
    logic [CAL_W-1:0] cal_q;
    logic [7:0]       ctrl_rd;
    logic             ctrl_wr;

    assign ctrl_wr = wr_en && (addr == CTRL_ADDR);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field_sel
        assign load_en[g] = wr_en && halt_q && (addr == ADDR_W'(g + 1));
    end
    assign load_val = wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            cal_q  <= '0;
        end else if (ctrl_wr) begin
            halt_q <= wdata[HALT_BIT];
            cal_q  <= wdata[CAL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (!rst_n)          hold_q[i] <= field_reset(i);
            else if (load_en[i]) hold_q[i] <= wdata;
            else if (copy_en)    hold_q[i] <= cnt[i];
        end
    end

    always_comb begin
        ctrl_rd              = '0;
        ctrl_rd[CAL_W-1:0]   = cal_q;
        ctrl_rd[HALT_BIT]    = halt_q;
        rdata                = ctrl_rd;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(i + 1)) rdata = hold_q[i];
        end
    end

    assign halt = halt_q;
    assign cal  = cal_q;

    AST_COPY_LOADS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_en && !wr_en) |=> (hold_q == $past(cnt))); // R6
    AST_FROZEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!copy_en && !wr_en) |=> $stable(hold_q)); // R7
    AST_UNHALTED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_q && !copy_en) |=> $stable(hold_q)); // R11
    AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (cal == $past(wdata[CAL_W-1:0]))); // R10

endmodule

// File: rtl/cal_shadow_top.sv
module cal_shadow_top
    import cal_pkg::*;
#(
    parameter int CAL_W    = 6,
    parameter int HALT_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic [CAL_W-1:0] trim_value
);

    field_vec_t            cnt;
    logic                  halt;
    logic                  copy_en;
    logic [NUM_FIELDS-1:0] load_en;
    logic [7:0]            load_val;

    initial begin
        assert (CAL_W <= HALT_BIT && HALT_BIT < 8 && ADDR_W == 3);
    end

    cal_counter_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt      (cnt)
    );

    cal_snapshot_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .halt    (halt),
        .copy_en (copy_en)
    );

    cal_host_regs #(
        .CAL_W    (CAL_W),
        .HALT_BIT (HALT_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .copy_en  (copy_en),
        .cnt      (cnt),
        .rdata    (bus_rdata),
        .halt     (halt),
        .cal      (trim_value),
        .load_en  (load_en),
        .load_val (load_val)
    );

endmodule

// File: tb/test_cal_shadow_top.sv
`timescale 1ns/1ps
module test_cal_shadow_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] trim_value;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cal_shadow_top i_cal_shadow_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick   (sec_tick),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .trim_value (trim_value)
    );

    task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, $sformatf("offset %0d", a), bus_rdata, exp);
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] d, input logic [7:0] mo,
                            input logic [7:0] y);
        do_write(3'd0, 8'h40);
        do_write(3'd1, s);  do_write(3'd2, mi); do_write(3'd3, h);
        do_write(3'd4, dw); do_write(3'd5, d);  do_write(3'd6, mo);
        do_write(3'd7, y);
        do_write(3'd0, 8'h00);
        do_tick();
    endtask

    task automatic t_reset();
        rd_check("R1", 3'd0, 8'h00);
        rd_check("R1", 3'd1, 8'h00);
        rd_check("R1", 3'd2, 8'h00);
        rd_check("R1", 3'd3, 8'h00);
        rd_check("R2", 3'd4, 8'h01);
        rd_check("R2", 3'd5, 8'h01);
        rd_check("R2", 3'd6, 8'h01);
        rd_check("R2", 3'd7, 8'h00);
        check("R1", "trim", {2'b00, trim_value}, 8'h00);
    endtask

    task automatic t_calibration();
        do_write(3'd0, 8'hEA);
        rd_check("R10", 3'd0, 8'h6A);
        check("R10", "trim", {2'b00, trim_value}, 8'h2A);
        do_write(3'd0, 8'h00);
        rd_check("R10", 3'd0, 8'h00);
    endtask

    task automatic t_unhalted_write();
        do_write(3'd3, 8'h12);
        rd_check("R11", 3'd3, 8'h00);
        do_tick();
        rd_check("R6", 3'd1, 8'h01);
        rd_check("R11", 3'd3, 8'h00);
    endtask

    task automatic t_full_rollover();
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        rd_check("R3", 3'd1, 8'h00);
        rd_check("R3", 3'd2, 8'h00);
        rd_check("R3", 3'd3, 8'h00);
        rd_check("R4", 3'd4, 8'h01);
        rd_check("R5", 3'd5, 8'h01);
        rd_check("R5", 3'd6, 8'h01);
        rd_check("R5", 3'd7, 8'h00);
    endtask

    task automatic t_month_lengths();
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        rd_check("R5", 3'd5, 8'h01);
        rd_check("R5", 3'd6, 8'h03);
        rd_check("R4", 3'd4, 8'h04);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h12);
        rd_check("R5", 3'd5, 8'h29);
        rd_check("R5", 3'd6, 8'h02);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h12);
        rd_check("R5", 3'd5, 8'h01);
        rd_check("R5", 3'd6, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
        rd_check("R5", 3'd5, 8'h01);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h11, 8'h05);
        rd_check("R5", 3'd5, 8'h01);
        rd_check("R5", 3'd6, 8'h12);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h10, 8'h05);
        rd_check("R5", 3'd5, 8'h31);
        rd_check("R5", 3'd6, 8'h10);
        set_time(8'h59, 8'h09, 8'h09, 8'h01, 8'h01, 8'h01, 8'h05);
        rd_check("R3", 3'd2, 8'h10);
        rd_check("R3", 3'd3, 8'h09);
    endtask

    task automatic t_halt_release();
        set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        rd_check("R6", 3'd1, 8'h11);
        do_write(3'd0, 8'h40);
        do_tick(); do_tick(); do_tick();
        rd_check("R7", 3'd1, 8'h11);
        do_write(3'd0, 8'h00);
        repeat (3) @(negedge clk);
        rd_check("R9", 3'd1, 8'h11);
        do_tick();
        rd_check("R7", 3'd1, 8'h15);
    endtask

    task automatic t_halt_during_copy();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h40;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_check("R8", 3'd1, 8'h16);
        do_tick();
        rd_check("R8", 3'd1, 8'h16);
        do_write(3'd0, 8'h00);
        do_tick();
        rd_check("R9", 3'd1, 8'h18);
    endtask

    task automatic t_halted_write();
        do_write(3'd0, 8'h40);
        do_write(3'd1, 8'h42);
        rd_check("R11", 3'd1, 8'h42);
        do_write(3'd0, 8'h00);
        do_tick();
        rd_check("R11", 3'd1, 8'h43);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_calibration();
        t_unhalted_write();
        t_full_rollover();
        t_month_lengths();
        t_halt_release();
        t_halt_during_copy();
        t_halted_write();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule